// File: doc/BRIEF.md
# Dimension-Order Route Computation Unit

This unit makes the routing decision for one switch of a two-dimensional k-ary network, wired either as a mesh or as a torus. Each packet that arrives supplies its destination coordinates, and the switch supplies its own coordinates. For each dimension the unit forms the signed offset from the switch to the destination and picks one of five output ports: +X, −X, +Y, −Y or the local node.

Routing follows strict dimension order. The X offset is driven to zero before any hop in Y is taken. In torus mode the X and Y dimensions each wrap around, so the unit takes the shorter direction around the ring. When both directions are the same length, it takes the + direction.

The unit also emits the signed offsets that remain once the chosen hop is taken. A downstream stage can carry these as the packet's updated hop counts. The decision is registered, so the result is ready one cycle after the request.

Top module: `dor_route_unit`

## Requirements
- R1: While reset is held and after its release, out_valid is 0, port_sel is 5'b00000 and both remaining offsets are 0 until the first valid request.
- R2: out_valid equals the in_valid of the previous cycle. A cycle with in_valid low leaves port_sel, rem_x and rem_y unchanged.
- R3: port_sel is one-hot with bit 0 = local, bit 1 = +X, bit 2 = −X, bit 3 = +Y, bit 4 = −Y. Exactly one bit is set whenever out_valid is 1.
- R4: In mesh mode (torus_en = 0), the signed X offset is dest_x − self_x. The unit selects +X when this offset is positive and −X when it is negative.
- R5: Y ports are chosen only when the effective X offset is zero. The direction in Y follows the sign of the effective Y offset.
- R6: When both effective offsets are zero, port_sel selects local.
- R7: In torus mode (torus_en = 1), each effective offset is the distance (dest − self) mod K, moved into the range −K/2+1 … K/2. This makes the unit take the shorter way around the ring.
- R8: In torus mode, a distance of exactly K/2 in a dimension resolves to the + direction.
- R9: rem_x and rem_y are two's-complement signed effective offsets with the chosen hop removed. The magnitude of the routed dimension drops by one, and the other dimension is unchanged.
- R10: torus_en, the destination and the self coordinates are sampled with each request independently, so consecutive requests may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request carries a destination this cycle |
| torus_en | input | 1 | 1 = torus wrap-around, 0 = mesh |
| dest_x | input | CW | Destination X coordinate |
| dest_y | input | CW | Destination Y coordinate |
| self_x | input | CW | This switch's X coordinate |
| self_y | input | CW | This switch's Y coordinate |
| out_valid | output | 1 | Decision registered from the previous cycle |
| port_sel | output | 5 | One-hot output port |
| rem_x | output | CW+2 | Signed X offset remaining after the hop |
| rem_y | output | CW+2 | Signed Y offset remaining after the hop |

## Verification
A faulty offset or a faulty wrap decision shows up one cycle after the request, in both port_sel and the remaining offsets. A sign error appears as the opposite port. A wrong tie rule appears only at a distance of exactly K/2, so those distances are driven on purpose. Breaking the dimension order shows up as a Y port while rem_x is still nonzero.

// File: rtl/dor_route_unit.sv
module dor_route_unit #(
  parameter int K  = 8,
  parameter int CW = $clog2(K)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                torus_en,
  input  logic [CW-1:0]       dest_x,
  input  logic [CW-1:0]       dest_y,
  input  logic [CW-1:0]       self_x,
  input  logic [CW-1:0]       self_y,
  output logic                out_valid,
  output logic [4:0]          port_sel,
  output logic signed [CW+1:0] rem_x,
  output logic signed [CW+1:0] rem_y
);
  localparam int W = CW + 2;
  localparam logic signed [W-1:0] KS   = W'(K);
  localparam logic signed [W-1:0] HALF = W'(K / 2);
  localparam logic signed [W-1:0] ONE  = W'(1);

  function automatic logic signed [W-1:0] eff_off(
    input logic [CW-1:0] dst, input logic [CW-1:0] src, input logic tor);
    logic signed [W-1:0] d;
    d = $signed({2'b00, dst}) - $signed({2'b00, src});
    if (tor) begin
      if (d < 0) d = d + KS;
      if (d > HALF) d = d - KS;
    end
    return d;
  endfunction

  logic signed [W-1:0] rx, ry, nx, ny;
  logic [4:0] pick;

  assign rx = eff_off(dest_x, self_x, torus_en);
  assign ry = eff_off(dest_y, self_y, torus_en);

  always_comb begin
    pick = 5'b00001;
    nx   = rx;
    ny   = ry;
    if (rx > 0)      begin pick = 5'b00010; nx = rx - ONE; end
    else if (rx < 0) begin pick = 5'b00100; nx = rx + ONE; end
    else if (ry > 0) begin pick = 5'b01000; ny = ry - ONE; end
    else if (ry < 0) begin pick = 5'b10000; ny = ry + ONE; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      port_sel  <= '0;
      rem_x     <= '0;
      rem_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        port_sel <= pick;
        rem_x    <= nx;
        rem_y    <= ny;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(port_sel))); // R2
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $countones(port_sel) == 1); // R3
  AST_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && (port_sel[3] || port_sel[4])) |-> rem_x == 0); // R5
  AST_LOCAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && port_sel[0]) |-> (rem_x == 0 && rem_y == 0)); // R6
  AST_TORUS_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && torus_en) |=> (rem_x <= HALF && rem_x >= -HALF && rem_y <= HALF && rem_y >= -HALF)); // R7
endmodule

// File: tb/dor_route_unit_bench.sv
module dor_route_unit_bench;
  localparam int K = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, torus_en = 1'b0;
  logic [CW-1:0] dest_x = '0, dest_y = '0, self_x = '0, self_y = '0;
  logic out_valid;
  logic [4:0] port_sel;
  logic signed [CW+1:0] rem_x, rem_y;

  int checks = 0, errors = 0;
  logic [4:0] last_port = '0;
  int last_rx = 0, last_ry = 0;

  always #4 clk = ~clk;

  dor_route_unit #(.K(K), .CW(CW)) u_dor_route_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .torus_en(torus_en),
    .dest_x(dest_x), .dest_y(dest_y), .self_x(self_x), .self_y(self_y),
    .out_valid(out_valid), .port_sel(port_sel), .rem_x(rem_x), .rem_y(rem_y));

  function automatic int offs(int s, int d, bit tor);
    int v;
    v = d - s;
    if (tor) begin
      if (v < 0) v += K;
      if (v > K / 2) v -= K;
    end
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic route(int sx, int sy, int dx, int dy, bit tor, string req);
    int ex, ey;
    logic [4:0] ep;
    ex = offs(sx, dx, tor);
    ey = offs(sy, dy, tor);
    if (ex > 0) begin ep = 5'b00010; ex--; end
    else if (ex < 0) begin ep = 5'b00100; ex++; end
    else if (ey > 0) begin ep = 5'b01000; ey--; end
    else if (ey < 0) begin ep = 5'b10000; ey++; end
    else ep = 5'b00001;
    in_valid = 1'b1; torus_en = tor;
    self_x = CW'(sx); self_y = CW'(sy); dest_x = CW'(dx); dest_y = CW'(dy);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " port"}, int'(port_sel), int'(ep));
    chk({req, " rem_x"}, int'(rem_x), ex);
    chk({req, " rem_y"}, int'(rem_y), ey);
    last_port = ep; last_rx = ex; last_ry = ey;
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    dest_x = CW'($urandom); dest_y = CW'($urandom); torus_en = 1'($urandom);
    @(negedge clk);
    chk("R2 idle valid", int'(out_valid), 0);
    chk("R2 idle port", int'(port_sel), int'(last_port));
    chk("R2 idle rem_x", int'(rem_x), last_rx);
    chk("R2 idle rem_y", int'(rem_y), last_ry);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 port", int'(port_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release port", int'(port_sel), 0);
    chk("R1 after release rem_x", int'(rem_x), 0);
    route(2, 3, 5, 1, 0, "R4 mesh +X");
    route(6, 3, 1, 3, 0, "R4 mesh -X");
    route(5, 1, 1, 1, 0, "R4 mesh -X at distance K/2");
    route(4, 2, 4, 7, 0, "R5 +Y after X done");
    route(4, 6, 4, 0, 0, "R5 -Y after X done");
    route(3, 3, 3, 3, 1, "R6 local");
    route(0, 0, 7, 0, 1, "R7 torus wrap -X");
    route(6, 0, 1, 0, 1, "R7 torus wrap +X");
    route(0, 1, 0, 7, 1, "R7 torus wrap -Y");
    route(0, 0, 4, 0, 1, "R8 tie +X");
    route(5, 2, 1, 2, 1, "R8 tie from above +X");
    route(2, 6, 2, 2, 1, "R8 tie +Y");
    route(1, 1, 7, 1, 0, "R10 mesh then");
    route(1, 1, 7, 1, 1, "R10 torus now");
    idle_check();
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) idle_check();
      else route($urandom_range(0, K - 1), $urandom_range(0, K - 1),
                 $urandom_range(0, K - 1), $urandom_range(0, K - 1),
                 1'($urandom), "R9 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule